// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic unit of an 8-bit accumulator machine. Each cycle it takes an operation code, an accumulator operand, a memory operand and an incoming carry bit. From these it produces a result and a write-back enable, both combinational. The negative, overflow, zero and carry flags are updated in a small register at the rising clock edge, but only when an operation is presented.

Addition and subtraction both chain through the carry. Subtraction treats carry as "no borrow", so a single-byte subtract needs carry set beforehand. Compare runs the subtraction with carry-in forced high and keeps only the flags. Bit-test copies the top two bits of the memory operand into N and V, and judges Z from the AND of both operands. The shift, rotate, increment and decrement group works on the accumulator operand. Each operation touches only its own flags and leaves the others as they were.

Top module: `acc_alu_top`

## Requirements
- R1: Op code 0 (add) gives res = (A + M + carry_in) mod 256 with wr_en = 1; C takes the carry out of bit 7.
- R2: Op code 1 (subtract) gives res = (A + ~M + carry_in) mod 256 with wr_en = 1; C = 1 means no borrow occurred.
- R3: For add and subtract only, V is set exactly when both addend operands (A and M for add, A and ~M for subtract) have equal bit 7 and the result's bit 7 differs from it.
- R4: Op code 2 (compare) sets N and Z from A - M and sets C = (A >= M unsigned), ignoring carry_in; wr_en = 0 and V is unchanged.
- R5: Op codes 3, 4 and 5 give A AND M, A OR M and A XOR M with wr_en = 1; C and V are unchanged.
- R6: Op code 6 (shift left) and op code 7 (shift right) move A by one bit and fill the vacated bit with 0; the bit shifted out goes to C; V is unchanged; wr_en = 1.
- R7: Op code 8 (rotate left) and op code 9 (rotate right) shift A by one bit, feed carry_in into the vacated bit and send the bit shifted out to C; V is unchanged; wr_en = 1.
- R8: Op code 10 gives A + 1 and op code 11 gives A - 1, both wrapping mod 256, with wr_en = 1; C and V are unchanged.
- R9: Op code 12 (bit test) sets N = M bit 7, V = M bit 6, Z = ((A AND M) == 0), leaves C unchanged and has wr_en = 0.
- R10: For every op code from 0 to 11, N takes bit 7 of the computed value and Z is 1 exactly when that value is zero.
- R11: All flags are 0 after reset. They change only at a rising edge with op_en = 1. Op codes 13 to 15 change no flag, and wr_en is 0 whenever op_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_en | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select (encodings in the requirements) |
| opnd_a | input | 8 | Accumulator operand |
| opnd_m | input | 8 | Memory operand |
| carry_in | input | 1 | Incoming carry for add, subtract and rotates |
| res | output | 8 | Computed value (combinational) |
| wr_en | output | 1 | Result is to be written back |
| flag_n | output | 1 | Registered negative flag |
| flag_v | output | 1 | Registered overflow flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |

## Verification
The hardest situation to reach from the ports is a flag that has to stay unchanged while it holds a 1. For example, V must survive a compare, a logic operation or a shift, and C must survive an increment after a carry-producing add. Random traffic rarely lines these up. The stimulus therefore chains directed pairs: a signed-overflow add or a carrying add first, then the operation that must leave the flag alone. A long random run follows, compared against a behavioural flag model on every operation.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_ASL = 4'd6,
    OP_LSR = 4'd7,
    OP_ROL = 4'd8,
    OP_ROR = 4'd9,
    OP_INC = 4'd10,
    OP_DEC = 4'd11,
    OP_BIT = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;

  // signed overflow from the sign bits of two addends and the sum
  function automatic logic signed_ovf(input logic a_msb, input logic b_msb,
                                      input logic r_msb);
    return (a_msb == b_msb) && (r_msb != a_msb);
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import accalu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] addend;
  logic         ci_eff;
  logic [W:0]   full;

  always_comb begin
    addend = (op == OP_ADD) ? m : ~m;
    ci_eff = (op == OP_CMP) ? 1'b1 : cin;
    full   = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, ci_eff};
    sum    = full[W-1:0];
    cout   = full[W];
    ovf    = signed_ovf(a[W-1], addend[W-1], full[W-1]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import accalu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_AND, OP_BIT: res = a & m;
      OP_OR:          res = a | m;
      OP_XOR:         res = a ^ m;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import accalu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    res  = '0;
    cout = cin;
    unique case (op)
      OP_ASL: {cout, res} = {a, 1'b0};
      OP_LSR: {res, cout} = {1'b0, a};
      OP_ROL: {cout, res} = {a, cin};
      OP_ROR: {res, cout} = {cin, a};
      OP_INC: res = a + ONE;
      OP_DEC: res = a - ONE;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import accalu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  flags_t nxt,
  output flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= nxt;
  end
endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
  import accalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_en,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_m,
  input  logic         carry_in,
  output logic [W-1:0] res,
  output logic         wr_en,
  output logic         flag_n,
  output logic         flag_v,
  output logic         flag_z,
  output logic         flag_c
);
  alu_op_e      op;
  logic [W-1:0] arith_sum, logic_res, shift_res;
  logic         arith_cout, arith_ovf, shift_cout;
  flags_t       flags_q, flags_nxt;
  logic         grp_arith, grp_logic, grp_shift;

  assign op = alu_op_e'(op_code);

  alu_arith #(.W(W)) u_arith (
    .op(op), .a(opnd_a), .m(opnd_m), .cin(carry_in),
    .sum(arith_sum), .cout(arith_cout), .ovf(arith_ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .op(op), .a(opnd_a), .m(opnd_m), .res(logic_res)
  );

  alu_shift #(.W(W)) u_shift (
    .op(op), .a(opnd_a), .cin(carry_in), .res(shift_res), .cout(shift_cout)
  );

  always_comb begin
    grp_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
    grp_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_BIT);
    grp_shift = (op_code >= 4'd6) && (op_code <= 4'd11);

    if (grp_arith)      res = arith_sum;
    else if (grp_logic) res = logic_res;
    else if (grp_shift) res = shift_res;
    else                res = '0;

    wr_en = op_en && (grp_arith || grp_logic || grp_shift)
                  && (op != OP_CMP) && (op != OP_BIT);
  end

  always_comb begin
    flags_nxt = flags_q;
    if (grp_arith || grp_logic || grp_shift) begin
      flags_nxt.n = res[W-1];
      flags_nxt.z = (res == '0);
    end
    unique case (op)
      OP_ADD, OP_SUB: begin
        flags_nxt.c = arith_cout;
        flags_nxt.v = arith_ovf;
      end
      OP_CMP:                         flags_nxt.c = arith_cout;
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: flags_nxt.c = shift_cout;
      OP_BIT: begin
        flags_nxt.n = opnd_m[W-1];
        flags_nxt.v = opnd_m[W-2];
      end
      default: ;
    endcase
  end

  alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .upd(op_en), .nxt(flags_nxt), .q(flags_q)
  );

  assign flag_n = flags_q.n;
  assign flag_v = flags_q.v;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
endmodule

// File: rtl/accalu_chk.sv
module accalu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_en,
  input logic [3:0]   op_code,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_m,
  input logic [W-1:0] res,
  input logic         wr_en,
  input logic         arith_cout,
  input logic         flag_n,
  input logic         flag_v,
  input logic         flag_z,
  input logic         flag_c
);
  p_cmp_no_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd2) |-> !wr_en);

  p_cmp_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == 4'd2) |=>
      (flag_c == ($past(opnd_a) >= $past(opnd_m))) && (flag_v == $past(flag_v)));

  p_cmp_cout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd2) |-> (arith_cout == (opnd_a >= opnd_m)));

  p_bit_nv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == 4'd12) |=>
      (flag_n == $past(opnd_m[W-1])) && (flag_v == $past(opnd_m[W-2]))
      && $stable(flag_c));

  p_incdec_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (op_code == 4'd10 || op_code == 4'd11)) |=>
      $stable(flag_c) && $stable(flag_v));

  p_logic_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code >= 4'd3 && op_code <= 4'd5) |=>
      $stable(flag_c) && $stable(flag_v));

  p_z_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && wr_en) |=> (flag_z == ($past(res) == '0)) && (flag_n == $past(res[W-1])));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_en || op_code >= 4'd13) |=>
      $stable(flag_n) && $stable(flag_v) && $stable(flag_z) && $stable(flag_c));

  p_no_wr_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |-> !wr_en);
endmodule

bind acc_alu_top accalu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_code(op_code),
  .opnd_a(opnd_a), .opnd_m(opnd_m), .res(res), .wr_en(wr_en),
  .arith_cout(arith_cout), .flag_n(flag_n), .flag_v(flag_v),
  .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/acc_alu_top_tb_top.sv
module acc_alu_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_en = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] opnd_a = 8'd0, opnd_m = 8'd0;
  logic       carry_in = 1'b0;
  logic [7:0] res;
  logic       wr_en, flag_n, flag_v, flag_z, flag_c;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // behavioural flag state: bit3 N, bit2 V, bit1 Z, bit0 C
  int mdl_flags = 0;

  always #5 clk = ~clk;

  acc_alu_top dut_i (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_m(opnd_m), .carry_in(carry_in),
    .res(res), .wr_en(wr_en), .flag_n(flag_n), .flag_v(flag_v),
    .flag_z(flag_z), .flag_c(flag_c)
  );

  function automatic string req_of(int op);
    case (op)
      0: return "R1";   1: return "R2";   2: return "R4";
      3, 4, 5: return "R5";
      6, 7: return "R6";  8, 9: return "R7";
      10, 11: return "R8"; 12: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(bit en, int op, int a, int m, bit ci);
    int r, t, n, v, z, c, wr;
    bit sets_nz;
    @(negedge clk);
    op_en = en; op_code = 4'(op); opnd_a = 8'(a); opnd_m = 8'(m); carry_in = ci;
    n = (mdl_flags >> 3) & 1; v = (mdl_flags >> 2) & 1;
    z = (mdl_flags >> 1) & 1; c = mdl_flags & 1;
    r = 0; wr = 1; sets_nz = 1;
    case (op)
      0: begin t = a + m + ci; r = t % 256; c = t / 256;
               v = (((a ^ r) & (m ^ r) & 128) != 0) ? 1 : 0; end
      1: begin t = a + (255 - m) + ci; r = t % 256; c = t / 256;
               v = (((a ^ r) & ((255 - m) ^ r) & 128) != 0) ? 1 : 0; end
      2: begin r = (a - m + 256) % 256; c = (a >= m) ? 1 : 0; wr = 0; end
      3: r = a & m;
      4: r = a | m;
      5: r = a ^ m;
      6: begin r = (a * 2) % 256; c = a / 128; end
      7: begin r = a / 2; c = a % 2; end
      8: begin r = (a * 2) % 256 + ci; c = a / 128; end
      9: begin r = a / 2 + 128 * ci; c = a % 2; end
      10: r = (a + 1) % 256;
      11: r = (a + 255) % 256;
      12: begin r = a & m; wr = 0; sets_nz = 0;
                n = (m >> 7) & 1; v = (m >> 6) & 1; z = (r == 0) ? 1 : 0; end
      default: begin wr = 0; sets_nz = 0; end
    endcase
    if (sets_nz) begin n = (r >> 7) & 1; z = (r == 0) ? 1 : 0; end
    if (!en) wr = 0;
    #1;
    if (op <= 12) check(req_of(op), int'(res), r, "result");
    check(en ? req_of(op) : "R11", int'(wr_en), wr, "wr_en");
    @(posedge clk);
    if (en) mdl_flags = n * 8 + v * 4 + z * 2 + c;
    #1;
    check(en ? req_of(op) : "R11", int'({flag_n, flag_v, flag_z, flag_c}),
          mdl_flags, "flags NVZC");
    if (en && (op == 0 || op == 1)) check("R3", int'(flag_v), (mdl_flags >> 2) & 1, "overflow");
    if (en && op <= 11) check("R10", int'({flag_n, flag_z}), ((mdl_flags >> 2) & 2) | ((mdl_flags >> 1) & 1), "N/Z");
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R11 watchdog: actual expired expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11", int'({flag_n, flag_v, flag_z, flag_c}), 0, "reset flags");
    @(negedge clk); rst_n = 1'b1;

    // R1 add corners
    run_op(1, 0, 8'h7F, 8'h01, 0);   // signed overflow, N=1
    run_op(1, 0, 8'hFF, 8'h01, 0);   // wrap to zero, C=1
    run_op(1, 0, 8'h10, 8'h20, 1);   // carry-in counts
    // R2 subtract corners
    run_op(1, 1, 8'h80, 8'h01, 1);   // signed overflow to 0x7F
    run_op(1, 1, 8'h05, 8'h03, 0);   // borrow in: 1
    run_op(1, 1, 8'h03, 8'h05, 1);   // borrow out: C=0
    // R4 compare: V kept at 1, carry_in ignored
    run_op(1, 0, 8'h7F, 8'h01, 0);
    run_op(1, 2, 8'h42, 8'h42, 0);
    run_op(1, 2, 8'h10, 8'h20, 1);
    // R5 logic keeps C and V
    run_op(1, 0, 8'hFF, 8'h81, 0);   // C=1, V=0
    run_op(1, 5, 8'h5A, 8'hFF, 0);   // XOR with all ones = NOT
    run_op(1, 3, 8'hF0, 8'h0F, 0);
    run_op(1, 4, 8'h00, 8'h80, 0);
    // R6 shifts
    run_op(1, 6, 8'h81, 8'h00, 1);
    run_op(1, 7, 8'h01, 8'h00, 1);
    // R7 rotates through carry
    run_op(1, 8, 8'h80, 8'h00, 1);
    run_op(1, 9, 8'h01, 8'h00, 1);
    run_op(1, 9, 8'h02, 8'h00, 0);
    // R8 inc/dec keep C and V
    run_op(1, 0, 8'hC0, 8'hC0, 0);   // C=1
    run_op(1, 10, 8'hFF, 8'h00, 0);
    run_op(1, 11, 8'h00, 8'h00, 1);
    // R9 bit test
    run_op(1, 12, 8'h3F, 8'hC0, 0);
    run_op(1, 12, 8'hFF, 8'h01, 1);
    // R11 idle and unused codes
    run_op(0, 0, 8'hFF, 8'hFF, 1);
    run_op(1, 13, 8'h00, 8'h00, 1);
    run_op(1, 15, 8'hFF, 8'h00, 0);

    for (int i = 0; i < 3000; i++)
      run_op(($urandom % 8) != 0, int'($urandom % 16), int'($urandom % 256),
             int'($urandom % 256), 1'($urandom % 2));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule